// File: doc/BRIEF.md
# Decimal Declet Codec

This block converts between the compressed 10-bit decimal declet form and plain binary-coded decimal. A declet packs three decimal digits (000 to 999) into ten bits. Small digits (0 to 7) keep their three low bits verbatim. Large digits (8 or 9) need only their lowest bit, and indicator bits say which digits are large. In decode mode each declet expands to three 4-bit digits. In encode mode each group of three digits folds into one declet.

The operand is a 64-bit word. It is handled as two independent 32-bit halves, and each half carries two declets or two digit triples. A mode input, sampled together with `in_valid`, picks the direction for each transaction. The mode may change on every transaction. The result is registered and appears one clock after the request, flagged by `out_valid`. The output word holds its value until the next request.

Top module: `dpd_codec`

## Requirements
- R1: Decode, canonical declets: when declet bit 3 is 0, the hundreds, tens and units digits are the zero-extended declet bits 9:7, 6:4 and 2:0. Otherwise large digits appear as 8 or 9 according to the indicator bits. Examples: 0x0A3 gives 1,2,3; 0x0AE gives 9,0,8; 0x0EE gives 9,8,8; 0x00E gives 8,8,0. Every decoded digit is in 0..9.
- R2: Decode, non-canonical declets: when bits 3:1 are 111 and bits 6:5 are 11, bits 9:8 are ignored. So 0x16E, 0x26E and 0x36E all give 8,8,8, and 0x17F gives 8,9,9. All 1024 declet values decode.
- R3: Encode: every digit triple 000..999 gives the declet whose decode is that triple. Examples: 1,2,3 gives 0x0A3; 0,8,0 gives 0x00A; 8,0,0 gives 0x00C; 8,8,8 gives 0x06E; 9,9,9 gives 0x0FF.
- R4: Round trip: decoding the encoded declet of any valid triple returns the original triple.
- R5: Decode layout per 32-bit half: the declet in half bits 9:0 goes to half bits 11:0, and the declet in bits 19:10 goes to bits 23:12. In each triple the hundreds digit is the top nibble. Bits 31:24 of the result are 0, and input bits 31:20 have no effect.
- R6: Encode layout per 32-bit half: the digit triple in half bits 11:0 (hundreds in 11:8) goes to declet bits 9:0, and the triple in bits 23:12 goes to bits 19:10. Bits 31:20 of the result are 0, and input bits 31:24 have no effect.
- R7: The two halves of the word (bits 31:0 and 63:32) are converted independently.
- R8: In encode mode a nibble above 9 is treated as large when its bit 3 is set, with only its bit 0 kept. So 0xF,0xA,0xC encodes like 9,8,8, and 0xB,5,0xD encodes like 9,5,9.
- R9: `out_valid` equals `in_valid` of the previous cycle. Synchronous reset clears `out_valid` and `out_word`.
- R10: `out_word` updates only in a cycle after `in_valid` was 1. Otherwise it holds, whatever `in_word` and `mode` do.
- R11: `mode` = 0 selects decode and `mode` = 1 selects encode, per transaction, including back-to-back transactions in alternating modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; captures the converted word |
| mode | input | 1 | 0 = declets to digits, 1 = digits to declets |
| in_word | input | 64 | Operand, two independent 32-bit halves |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 64 | Registered conversion result |

## Verification
Every converted word is due exactly one clock after the edge that samples `in_valid`, with `out_valid` high in that same cycle. The bench drives on the falling edge and samples on the next falling edge, half a period after the capturing edge. In streaming tests it checks the result of request k while request k+1 is being driven. Hold and reset behaviour is checked at the same offset: one falling edge after reset, and several falling edges after stimulus that must not load.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  localparam int DECLET_W = 10;
  localparam int DIGIT_W  = 4;
  localparam int TRIPLE_W = 3 * DIGIT_W;

  typedef enum logic {
    MODE_DECODE = 1'b0,
    MODE_ENCODE = 1'b1
  } codec_mode_e;

  // Declet bits, high to low: p q r s t u v w x y.
  function automatic logic [TRIPLE_W-1:0] dpd_unpack(input logic [DECLET_W-1:0] dl);
    logic p, q, r, s, t, u, v, w, x, y;
    logic [DIGIT_W-1:0] hun, ten, one;
    {p, q, r, s, t, u, v, w, x, y} = dl;
    hun = {1'b0, p, q, r};
    ten = {1'b0, s, t, u};
    one = {1'b0, w, x, y};
    if (v) begin
      unique case ({w, x})
        2'b00: one = {3'b100, y};
        2'b01: begin
          ten = {3'b100, u};
          one = {1'b0, s, t, y};
        end
        2'b10: begin
          hun = {3'b100, r};
          one = {1'b0, p, q, y};
        end
        default: begin
          unique case ({s, t})
            2'b00: begin
              hun = {3'b100, r};
              ten = {3'b100, u};
              one = {1'b0, p, q, y};
            end
            2'b01: begin
              hun = {3'b100, r};
              ten = {1'b0, p, q, u};
              one = {3'b100, y};
            end
            2'b10: begin
              ten = {3'b100, u};
              one = {3'b100, y};
            end
            default: begin
              hun = {3'b100, r};
              ten = {3'b100, u};
              one = {3'b100, y};
            end
          endcase
        end
      endcase
    end
    return {hun, ten, one};
  endfunction

  // Digit flags a, e, i are nibble bit 3; remaining bits b c d, f g h, j k m.
  function automatic logic [DECLET_W-1:0] dpd_pack(input logic [TRIPLE_W-1:0] dg);
    logic a, b, c, d, e, f, g, h, i, j, k, m;
    logic [DECLET_W-1:0] res;
    {a, b, c, d} = dg[11:8];
    {e, f, g, h} = dg[7:4];
    {i, j, k, m} = dg[3:0];
    unique case ({a, e, i})
      3'b000: res = {b, c, d, f, g, h, 1'b0, j, k, m};
      3'b001: res = {b, c, d, f, g, h, 3'b100, m};
      3'b010: res = {b, c, d, j, k, h, 3'b101, m};
      3'b100: res = {j, k, d, f, g, h, 3'b110, m};
      3'b110: res = {j, k, d, 2'b00, h, 3'b111, m};
      3'b101: res = {f, g, d, 2'b01, h, 3'b111, m};
      3'b011: res = {b, c, d, 2'b10, h, 3'b111, m};
      default: res = {2'b00, d, 2'b11, h, 3'b111, m};
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dpd_declet_dec.sv
module dpd_declet_dec
  import dpd_pkg::*;
(
  input  logic [DECLET_W-1:0] declet_i,
  output logic [TRIPLE_W-1:0] digits_o
);
  always_comb digits_o = dpd_unpack(declet_i);
endmodule

// File: rtl/dpd_declet_enc.sv
module dpd_declet_enc
  import dpd_pkg::*;
(
  input  logic [TRIPLE_W-1:0] digits_i,
  output logic [DECLET_W-1:0] declet_o
);
  always_comb declet_o = dpd_pack(digits_i);
endmodule

// File: rtl/dpd_half.sv
module dpd_half
  import dpd_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int LANES  = 2
) (
  input  logic              mode,
  input  logic [HALF_W-1:0] half_in,
  output logic [HALF_W-1:0] half_out
);
  localparam int DIG_SPAN = LANES * TRIPLE_W;
  localparam int DEC_SPAN = LANES * DECLET_W;

  logic [DIG_SPAN-1:0] dec_digits;
  logic [DEC_SPAN-1:0] enc_declets;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dpd_declet_dec u_dec (
      .declet_i (half_in[l*DECLET_W +: DECLET_W]),
      .digits_o (dec_digits[l*TRIPLE_W +: TRIPLE_W])
    );
    dpd_declet_enc u_enc (
      .digits_i (half_in[l*TRIPLE_W +: TRIPLE_W]),
      .declet_o (enc_declets[l*DECLET_W +: DECLET_W])
    );
  end

  if (HALF_W > DIG_SPAN) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^half_in[HALF_W-1:DIG_SPAN];
  end

  always_comb begin
    if (codec_mode_e'(mode) == MODE_ENCODE) half_out = HALF_W'(enc_declets);
    else                                    half_out = HALF_W'(dec_digits);
  end
endmodule

// File: rtl/dpd_codec.sv
module dpd_codec
  import dpd_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int HALVES = WORD_W / HALF_W;

  logic [WORD_W-1:0] next_word;
  logic              load_en;

  assign load_en = in_valid;

  for (genvar hh = 0; hh < HALVES; hh++) begin : g_half
    dpd_half #(.HALF_W(HALF_W), .LANES(LANES)) u_half (
      .mode     (mode),
      .half_in  (in_word[hh*HALF_W +: HALF_W]),
      .half_out (next_word[hh*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= load_en;
      if (load_en) out_word <= next_word;
    end
  end
endmodule

// File: rtl/dpd_codec_chk.sv
module dpd_codec_chk #(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mode,
  input logic [WORD_W-1:0] out_word,
  input logic              out_valid
);
  localparam int HALVES   = WORD_W / HALF_W;
  localparam int DIG_SPAN = LANES * 12;
  localparam int DEC_SPAN = LANES * 10;

  function automatic logic top_clear(input logic [WORD_W-1:0] w, input int from);
    logic ok;
    ok = 1'b1;
    for (int hh = 0; hh < HALVES; hh++)
      for (int b = from; b < HALF_W; b++)
        if (w[hh*HALF_W + b]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic digits_ok(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int hh = 0; hh < HALVES; hh++)
      for (int n = 0; n < DIG_SPAN/4; n++)
        if (w[hh*HALF_W + 4*n +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_word == '0)); // R9

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R9

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_word)); // R10

  AST_DEC_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(mode)) |-> top_clear(out_word, DIG_SPAN)); // R5

  AST_ENC_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(mode)) |-> top_clear(out_word, DEC_SPAN)); // R6

  AST_DEC_DIGITS_BCD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(mode)) |-> digits_ok(out_word)); // R1
endmodule

bind dpd_codec dpd_codec_chk #(.WORD_W(WORD_W), .HALF_W(HALF_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .out_word  (out_word),
  .out_valid (out_valid)
);

// File: tb/test_dpd_codec.sv
module test_dpd_codec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic [63:0] out_word;

  int checks = 0;
  int errors = 0;
  int inv_tab [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpd_codec i_dpd_codec (
    .clk (clk), .rst (rst), .in_valid (in_valid), .mode (mode),
    .in_word (in_word), .out_valid (out_valid), .out_word (out_word)
  );

  // Reference encoder written from the bit layout rules, digit value form.
  function automatic int ref_enc(input int hun, input int ten, input int one);
    int r;
    bit big_h, big_t, big_o;
    big_h = hun >= 8; big_t = ten >= 8; big_o = one >= 8;
    r = one & 1;
    if (!big_h && !big_t && !big_o)
      r = ((hun & 7) << 7) | ((ten & 7) << 4) | (one & 7);
    else if (!big_h && !big_t && big_o)
      r = ((hun & 7) << 7) | ((ten & 7) << 4) | 8 | (one & 1);
    else if (!big_h && big_t && !big_o)
      r = ((hun & 7) << 7) | (((one >> 1) & 3) << 5) | ((ten & 1) << 4) | 10 | (one & 1);
    else if (big_h && !big_t && !big_o)
      r = (((one >> 1) & 3) << 8) | ((hun & 1) << 7) | ((ten & 7) << 4) | 12 | (one & 1);
    else if (big_h && big_t && !big_o)
      r = (((one >> 1) & 3) << 8) | ((hun & 1) << 7) | ((ten & 1) << 4) | 14 | (one & 1);
    else if (big_h && !big_t && big_o)
      r = (((ten >> 1) & 3) << 8) | ((hun & 1) << 7) | 32 | ((ten & 1) << 4) | 14 | (one & 1);
    else if (!big_h && big_t && big_o)
      r = ((hun & 7) << 7) | 64 | ((ten & 1) << 4) | 14 | (one & 1);
    else
      r = ((hun & 1) << 7) | 96 | ((ten & 1) << 4) | 14 | (one & 1);
    return r;
  endfunction

  function automatic int bcd3(input int v);
    return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xact(input logic md, input logic [63:0] w, output logic [63:0] res);
    @(negedge clk);
    mode = md; in_word = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_word;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset out_word", out_word, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_examples;
    logic [63:0] r;
    xact(1'b0, 64'h0A3, r); check("R1 dec 0x0A3", r, 64'h123);
    xact(1'b0, 64'h0AE, r); check("R1 dec 0x0AE", r, 64'h908);
    xact(1'b0, 64'h0EE, r); check("R1 dec 0x0EE", r, 64'h988);
    xact(1'b0, 64'h00E, r); check("R1 dec 0x00E", r, 64'h880);
    xact(1'b0, 64'h16E, r); check("R2 dec 0x16E", r, 64'h888);
    xact(1'b0, 64'h26E, r); check("R2 dec 0x26E", r, 64'h888);
    xact(1'b0, 64'h36E, r); check("R2 dec 0x36E", r, 64'h888);
    xact(1'b0, 64'h17F, r); check("R2 dec 0x17F", r, 64'h899);
    xact(1'b1, 64'h123, r); check("R3 enc 123", r, 64'h0A3);
    xact(1'b1, 64'h080, r); check("R3 enc 080", r, 64'h00A);
    xact(1'b1, 64'h800, r); check("R3 enc 800", r, 64'h00C);
    xact(1'b1, 64'h888, r); check("R3 enc 888", r, 64'h06E);
    xact(1'b1, 64'h999, r); check("R3 enc 999", r, 64'h0FF);
  endtask

  task automatic t_decode_sweep;
    logic [63:0] w, e, r;
    for (int k = 0; k < 256; k++) begin
      w = '0; e = '0;
      for (int q = 0; q < 4; q++) begin
        int dl, hh, ln;
        dl = (k * 4 + q + 300 * q) % 1024;
        hh = q / 2; ln = q % 2;
        w[hh*32 + 10*ln +: 10] = dl[9:0];
        e[hh*32 + 12*ln +: 12] = inv_tab[dl][11:0];
      end
      w[31:20] = 12'(k * 37 + 5);
      w[63:52] = 12'(~(k * 91));
      xact(1'b0, w, r);
      check("R1 R2 R5 R7 decode sweep", r, e);
    end
  endtask

  task automatic t_encode_sweep;
    logic [63:0] w, e, r;
    for (int k = 0; k < 250; k++) begin
      w = '0; e = '0;
      for (int q = 0; q < 4; q++) begin
        int v, hh, ln;
        v = (k * 4 + q + 250 * q) % 1000;
        hh = q / 2; ln = q % 2;
        w[hh*32 + 12*ln +: 12] = bcd3(v)[11:0];
        e[hh*32 + 10*ln +: 10] = ref_enc(v / 100, (v / 10) % 10, v % 10);
      end
      w[31:24] = 8'(k ^ 8'hA5);
      w[63:56] = 8'(k * 13);
      xact(1'b1, w, r);
      check("R3 R6 R7 encode sweep", r, e);
    end
  endtask

  task automatic t_round_trip;
    logic [63:0] w, r1, r2;
    for (int k = 0; k < 250; k++) begin
      w = '0;
      for (int q = 0; q < 4; q++)
        w[(q/2)*32 + 12*(q%2) +: 12] = bcd3((k + 250 * q) % 1000)[11:0];
      xact(1'b1, w, r1);
      xact(1'b0, r1, r2);
      check("R4 round trip", r2, w);
    end
  endtask

  task automatic t_bad_nibbles;
    logic [63:0] r;
    xact(1'b1, 64'hFAC, r);
    check("R8 enc FAC", r, 64'(ref_enc(9, 8, 8)));
    xact(1'b1, {32'h0000_0B5D, 32'h0}, r);
    check("R8 enc B5D high half", r, {22'd0, 10'(ref_enc(9, 5, 9)), 32'd0});
  endtask

  task automatic t_valid_hold;
    logic [63:0] r, keep;
    xact(1'b0, 64'h0A3, r);
    keep = r;
    check("R9 valid one cycle", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R9 valid drops", {63'd0, out_valid}, 64'd0);
    mode = 1'b1; in_word = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R10 hold word", out_word, keep);
    check("R10 hold valid", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears word", out_word, 64'd0);
    check("R9 reset clears valid", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0; rst = 1'b0;
  endtask

  task automatic t_stream;
    logic [63:0] ws [6];
    logic [63:0] es [6];
    ws[0] = 64'h0AE; es[0] = 64'h908;
    ws[1] = 64'h999; es[1] = 64'h0FF;
    ws[2] = {32'h0EE, 32'h00E}; es[2] = {32'h988, 32'h880};
    ws[3] = {32'h888, 32'h080}; es[3] = {32'h06E, 32'h00A};
    ws[4] = 64'h17F; es[4] = 64'h899;
    ws[5] = 64'h800; es[5] = 64'h00C;
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check("R11 stream word", out_word, es[k-1]);
        check("R11 stream valid", {63'd0, out_valid}, 64'd1);
      end
      if (k < 6) begin
        in_word = ws[k]; mode = k[0]; in_valid = 1'b1;
      end else in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int v = 0; v < 1000; v++)
      inv_tab[ref_enc(v / 100, (v / 10) % 10, v % 10)] = bcd3(v);
    for (int d = 0; d < 1024; d++)
      if ((d & 14) == 14 && (d & 96) == 96) inv_tab[d] = inv_tab[d & 255];
    t_reset();
    t_examples();
    t_decode_sweep();
    t_encode_sweep();
    t_round_trip();
    t_bad_nibbles();
    t_valid_hold();
    t_stream();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule